// File: doc/BRIEF.md
# Tree Leading-Zero Counter

This block reports how many zero bits sit above the most significant set bit of a 24-bit word. Bit 23 is the top bit, so a word with bit 23 set gives a count of 0. A word with only bit 0 set gives 23. A word with no bits set gives 24 and raises a separate all-zero flag.

The priority is not found by scanning the bits one at a time. Each 4-bit slice of the word goes into a small priority cell, which produces a "slice has a one" flag and a 2-bit position within the slice. The same 4-input priority cell then merges the slice flags four at a time. A last stage picks between the two merged halves. The word is padded at its low end to 32 bits, which makes the tree regular. The padding cannot change the count of a non-zero word.

The result is registered on the rising clock edge whenever the input-valid strobe is high. An output-valid strobe follows the input strobe one cycle later. When no new word is presented, the registered result holds.

Top module: `lzc_tree`

## Requirements
- R1: For a non-zero word presented with `in_valid` high, `lz_count` on the next cycle equals 23 minus the index of the highest set bit, where bit 23 is the most significant.
- R2: When bit 23 of the word is set, `lz_count` is 0 whatever the lower bits hold.
- R3: When the word is all zeros, `lz_count` is 24 and `all_zero` is 1 on the next cycle.
- R4: When the word is non-zero, `all_zero` is 0 and `lz_count` is below 24.
- R5: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R6: When `in_valid` is low, `lz_count` and `all_zero` keep their previous values, even if `in_word` changes.
- R7: While `rst_n` is low, `out_valid` is 0, `lz_count` is 24 and `all_zero` is 1.
- R8: A word whose only set bit is bit 0 gives a count of 23. This checks the lowest slice against the zero padding below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | High when `in_word` holds a word to encode |
| in_word | input | 24 | Word whose leading zeros are counted |
| lz_count | output | 5 | Registered leading-zero count, 0 to 24 |
| all_zero | output | 1 | Registered flag: the last word was all zeros |
| out_valid | output | 1 | High one cycle after `in_valid` was high |

## Verification
The bench drives a single set bit through every one of the 24 positions. A merge stage that takes the position from the wrong slice, or that gets the weight of a slice index wrong, gives wrong counts at the slice and half boundaries (bits 3/4, 15/16 and so on). The all-zero word and the bit-0-only word catch designs where the low-end padding leaks into the result: such a design reports 32 or a padded position instead of 24 or 23. Dense words, including all ones and random words, catch a priority cell that picks the lowest set bit instead of the highest. Changing `in_word` while `in_valid` is low exposes a result register that does not hold its value.

// File: rtl/lzc_tree.sv
module lzc_tree #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1),
  localparam int PW = 32,
  localparam int NG = PW / 4,
  localparam int NB = NG / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  output logic [CW-1:0] lz_count,
  output logic          all_zero,
  output logic          out_valid
);

  function automatic logic [1:0] pe4(input logic [3:0] v);
    casez (v)
      4'b1???: pe4 = 2'd0;
      4'b01??: pe4 = 2'd1;
      4'b001?: pe4 = 2'd2;
      default: pe4 = 2'd3;
    endcase
  endfunction

  logic [PW-1:0] padded;
  logic [NG-1:0] g_vld;
  logic [1:0]    g_lz [NG];
  logic [NB-1:0] b_vld;
  logic [3:0]    b_lz [NB];
  logic          top_vld;
  logic [4:0]    top_lz;

  assign padded = {in_word, {(PW - W){1'b0}}};

  for (genvar g = 0; g < NG; g++) begin : g_slice
    assign g_vld[g] = |padded[4*g +: 4];
    assign g_lz[g]  = pe4(padded[4*g +: 4]);
  end

  for (genvar b = 0; b < NB; b++) begin : g_block
    logic [1:0] sel;
    assign sel      = pe4(g_vld[4*b +: 4]);
    assign b_vld[b] = |g_vld[4*b +: 4];
    assign b_lz[b]  = {sel, g_lz[4*b + 3 - int'(sel)]};
  end

  assign top_vld = |b_vld;
  assign top_lz  = b_vld[1] ? {1'b0, b_lz[1]} : {1'b1, b_lz[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lz_count  <= CW'(W);
      all_zero  <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        all_zero <= !top_vld;
        lz_count <= top_vld ? CW'(top_lz) : CW'(W);
      end
    end
  end

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_zero |-> lz_count == CW'(W));
  // R4
  nonzero_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_zero |-> lz_count < CW'(W));
  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lz_count) && $stable(all_zero));
  // R2
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_word[W-1] |=> lz_count == '0 && !all_zero);
  // R3
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_word == '0 |=> all_zero);

endmodule

// File: tb/lzc_tree_tb_top.sv
module lzc_tree_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [23:0] in_word = '0;
  logic [4:0]  lz_count;
  logic        all_zero;
  logic        out_valid;
  int checks = 0;
  int errors = 0;

  localparam int NV = 10;
  localparam logic [23:0] VW [NV] = '{24'h800000, 24'hFFFFFF, 24'h400000, 24'h0F0000,
    24'h00A5A5, 24'h000100, 24'h000010, 24'h000001, 24'h000003, 24'h080001};
  localparam logic [4:0] VC [NV] = '{5'd0, 5'd0, 5'd1, 5'd4, 5'd8, 5'd15, 5'd19,
    5'd23, 5'd22, 5'd4};

  always #5 clk = ~clk;

  lzc_tree dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .lz_count(lz_count), .all_zero(all_zero), .out_valid(out_valid));

  function automatic int ref_lz(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) if (w[i]) return 23 - i;
    return 24;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [23:0] w, input string req);
    @(negedge clk);
    in_valid = 1;
    in_word = w;
    @(negedge clk);
    in_valid = 0;
    check(req, lz_count, ref_lz(w));
    check({req, " zero flag"}, all_zero, (w == 0) ? 1 : 0);
    check("R5 out_valid", out_valid, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", out_valid, 0);
    check("R7 reset count", lz_count, 24);
    check("R7 reset zero flag", all_zero, 1);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_word = VW[i];
      @(negedge clk);
      in_valid = 0;
      check("R1 R2 table count", lz_count, VC[i]);
      check("R4 table zero flag", all_zero, 0);
    end

    for (int b = 0; b < 24; b++) apply(24'(1) << b, "R1 single bit");
    apply(24'h000001, "R8 lowest bit");
    apply(24'h800001, "R2 top bit with low bits");
    apply(24'h000000, "R3 all zero");
    for (int i = 0; i < 200; i++) apply(24'($urandom) >> ($urandom % 24), "R1 random");

    apply(24'h001000, "R1 before hold");
    @(negedge clk);
    in_word = 24'h800000;
    @(negedge clk);
    check("R6 hold count", lz_count, 11);
    check("R6 hold zero flag", all_zero, 0);
    check("R5 idle out_valid", out_valid, 0);

    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R7 reset again count", lz_count, 24);
    check("R7 reset again out_valid", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule